// File: doc/BRIEF.md
# Deferred-Commit Register Bank Store

This block holds sixteen 8-bit setting registers for a digital potentiometer. They are grouped as four banks of four. A serial front end decodes frames and hands the store two kinds of request. The first is a direct write of a data byte to any bank and register. The second is a transfer that copies the present wiper value into one register of bank 0. The bank input is ignored on a transfer, because only bank 0 takes part in moves to or from the wiper. Reads are combinational and use their own bank and register address, so the front end can serve any of the sixteen locations.

A request is not applied when it arrives. It is held as pending and committed only when chip select rises at the end of that frame. A commit is refused while the write-protect input is low. An accepted commit starts a store cycle whose length, in clock cycles, is the parameter `STORE_CYCLES`. Throughout that cycle the busy flag is set and every register keeps its old value. The new byte lands in the same clock edge that clears the flag. Register 0 of bank 0 is always presented on its own output so that it can be loaded into the wiper at power-up.

Top module: `nv_bank_store`

## Requirements
- R1: After reset all sixteen registers read 0, busy is 0 and `dr0` is 0.
- R2: The register index is `{bank, sel}`. `bank` picks a group of four and `sel` picks the register within it. `rd_data` shows the register at `{rd_bank, rd_sel}` in the same cycle.
- R3: A select window (`cs_n` low, then high) that carries no request leaves every register unchanged and does not raise busy.
- R4: If `wp_n` is 0 on the clock edge where `cs_n` is first seen high, the pending request is discarded. Busy stays 0 and the target register is unchanged.
- R5: An accepted commit raises busy on the clock edge where `cs_n` is first seen high. Busy then stays high for exactly `STORE_CYCLES` cycles.
- R6: While busy is high, reads return the previous contents. The new value is readable from the cycle in which busy is low again.
- R7: Requests that arrive while busy is high are ignored, including when their window closes during or after the store cycle.
- R8: A transfer (`xfer_req`) stores `wiper` into bank 0 register `sel`, whatever the value of `bank`.
- R9: `dr0` always equals bank 0 register 0.
- R10: Within one window, a later request replaces an earlier one. When `wr_req` and `xfer_req` are sampled in the same cycle, the data write wins.
- R11: A request sampled while `cs_n` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; its rising edge commits |
| wp_n | input | 1 | Write protect, active low; low blocks commits |
| wr_req | input | 1 | One-cycle pulse: complete direct write frame received |
| xfer_req | input | 1 | One-cycle pulse: complete wiper-to-register frame received |
| bank | input | 2 | Bank of the request |
| sel | input | 2 | Register of the request within its bank |
| wdata | input | 8 | Data byte of a direct write |
| wiper | input | 8 | Present wiper position, source of a transfer |
| rd_bank | input | 2 | Bank of the read address |
| rd_sel | input | 2 | Register of the read address |
| rd_data | output | 8 | Contents of the addressed register |
| busy | output | 1 | Store cycle in progress |
| dr0 | output | 8 | Bank 0 register 0, for power-up recall |

## Verification
Busy rises at the first clock edge that sees `cs_n` high after a request. It is therefore checked at the falling edge that follows, and then at each of the next `STORE_CYCLES` falling edges. The bench expects `STORE_CYCLES` highs followed by one low. The old register value is checked at the first busy sample. The new value is checked at the sample where busy has dropped, because the register write and the end of the cycle share one edge. Refused commits are checked one and three samples after the window closes, by looking at busy and at the read port.

// File: rtl/nv_bank_store.sv
module nv_bank_store #(
  parameter int DW           = 8,
  parameter int NBANK        = 4,
  parameter int NREG         = 4,
  parameter int STORE_CYCLES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     wp_n,
  input  logic                     wr_req,
  input  logic                     xfer_req,
  input  logic [$clog2(NBANK)-1:0] bank,
  input  logic [$clog2(NREG)-1:0]  sel,
  input  logic [DW-1:0]            wdata,
  input  logic [DW-1:0]            wiper,
  input  logic [$clog2(NBANK)-1:0] rd_bank,
  input  logic [$clog2(NREG)-1:0]  rd_sel,
  output logic [DW-1:0]            rd_data,
  output logic                     busy,
  output logic [DW-1:0]            dr0
);
  localparam int BKW   = $clog2(NBANK);
  localparam int AW    = $clog2(NBANK * NREG);
  localparam int CW    = $clog2(STORE_CYCLES + 1);
  localparam int DEPTH = NBANK * NREG;

  logic [DW-1:0] mem [DEPTH];
  logic          cs_q, pend;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;
  logic [CW-1:0] cnt;

  wire cs_rise = cs_n & ~cs_q;
  wire take    = ~cs_n & ~busy & (wr_req | xfer_req);
  wire done    = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      pend     <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      cs_q <= cs_n;
      if (take) begin
        pend     <= 1'b1;
        tgt_addr <= wr_req ? AW'({bank, sel}) : AW'({BKW'(0), sel});
        tgt_data <= wr_req ? wdata : wiper;
      end
      if (cs_rise) pend <= 1'b0;
      if (busy) begin
        if (done) busy <= 1'b0;
        else      cnt  <= cnt - 1'b1;
      end else if (cs_rise && pend && wp_n) begin
        busy <= 1'b1;
        cnt  <= CW'(STORE_CYCLES - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (done) begin
      mem[tgt_addr] <= tgt_data;
    end
  end

  assign rd_data = mem[AW'({rd_bank, rd_sel})];
  assign dr0     = mem[0];

  a_r4_commit_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_n && !cs_q && wp_n && pend));

  a_r7_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tgt_addr) && $stable(tgt_data)));

  a_r6_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> $stable(dr0));

  a_r11_deselected_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !pend) |=> !pend);
endmodule

// File: tb/tb_nv_bank_store.sv
module tb_nv_bank_store;
  localparam int S = 8;

  logic clk = 0, rst_n = 0, cs_n = 1, wp_n = 1, wr_req = 0, xfer_req = 0;
  logic [1:0] bank = 0, sel = 0, rd_bank = 0, rd_sel = 0;
  logic [7:0] wdata = 0, wiper = 0;
  logic [7:0] rd_data, dr0;
  logic       busy;
  int nchk = 0, nfail = 0;
  logic [7:0] mdl [16];

  always #2 clk = ~clk;

  nv_bank_store #(.STORE_CYCLES(S)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .wr_req(wr_req),
    .xfer_req(xfer_req), .bank(bank), .sel(sel), .wdata(wdata), .wiper(wiper),
    .rd_bank(rd_bank), .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy), .dr0(dr0));

  typedef struct packed {
    logic       op;
    logic [1:0] bk;
    logic [1:0] sl;
    logic [7:0] data;
    logic [7:0] wip;
    logic       wp;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{1'b0, 2'd1, 2'd2, 8'h5A, 8'h00, 1'b1, 8'h5A},
    '{1'b0, 2'd3, 2'd3, 8'hC3, 8'h00, 1'b1, 8'hC3},
    '{1'b1, 2'd2, 2'd1, 8'h00, 8'h77, 1'b1, 8'h77},
    '{1'b0, 2'd1, 2'd2, 8'h11, 8'h00, 1'b0, 8'h5A},
    '{1'b0, 2'd0, 2'd0, 8'hA5, 8'h00, 1'b1, 8'hA5},
    '{1'b1, 2'd0, 2'd3, 8'h00, 8'h3C, 1'b1, 8'h3C}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic op, input logic [1:0] b, input logic [1:0] s,
                       input logic [7:0] d, input logic [7:0] w);
    @(negedge clk); cs_n = 0; bank = b; sel = s; wdata = d; wiper = w;
    @(negedge clk); wr_req = !op; xfer_req = op;
    @(negedge clk); wr_req = 0; xfer_req = 0;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [7:0] exp);
    rd_bank = 2'(a >> 2); rd_sel = 2'(a);
    #0.1 check(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 dr0", dr0, 0);
    for (int i = 0; i < 16; i++) rd_chk("R1 reg", i, 8'h00);

    for (int k = 0; k < 6; k++) begin
      int eff;
      logic [7:0] old;
      eff = TBL[k].op ? int'(TBL[k].sl) : int'({TBL[k].bk, TBL[k].sl});
      old = mdl[eff];
      rd_bank = 2'(eff >> 2); rd_sel = 2'(eff);
      wp_n = TBL[k].wp;
      frame(TBL[k].op, TBL[k].bk, TBL[k].sl, TBL[k].data, TBL[k].wip);
      if (TBL[k].wp) begin
        for (int i = 0; i < S; i++) begin
          @(negedge clk);
          check("R5 busy high", busy, 1);
          if (i == 0) check("R6 old value while busy", rd_data, old);
        end
        @(negedge clk);
        check("R5 busy low", busy, 0);
        check(TBL[k].op ? "R8 transfer value" : "R2 write value", rd_data, TBL[k].exp);
        mdl[eff] = TBL[k].exp;
      end else begin
        @(negedge clk);
        check("R4 protected no busy", busy, 0);
        repeat (2) @(negedge clk);
        check("R4 protected unchanged", rd_data, TBL[k].exp);
      end
      wp_n = 1;
      check("R9 dr0", dr0, mdl[0]);
    end
    // R8 bank input ignored on transfer
    rd_chk("R8 bank2 untouched", 9, 8'h00);
    rd_chk("R2 bank3 reg3", 15, 8'hC3);

    // R7 request during busy ignored
    frame(1'b0, 2'd2, 2'd2, 8'h99, 8'h00);
    frame(1'b0, 2'd2, 2'd3, 8'h44, 8'h00);
    repeat (S + 3) @(negedge clk);
    check("R7 no second store", busy, 0);
    rd_chk("R2 first write", 10, 8'h99);
    rd_chk("R7 ignored write", 11, 8'h00);

    // R3 empty window
    @(negedge clk); cs_n = 0;
    repeat (3) @(negedge clk); cs_n = 1;
    @(negedge clk);
    check("R3 empty window busy", busy, 0);
    rd_chk("R3 reg12 unchanged", 12, 8'h00);

    // R11 request while deselected
    @(negedge clk); bank = 2'd3; sel = 2'd0; wdata = 8'hEE; wr_req = 1;
    @(negedge clk); wr_req = 0; cs_n = 0;
    @(negedge clk); cs_n = 1;
    @(negedge clk);
    check("R11 deselected busy", busy, 0);
    repeat (2) @(negedge clk);
    rd_chk("R11 reg12 unchanged", 12, 8'h00);

    // R10 later request replaces earlier
    @(negedge clk); cs_n = 0; bank = 2'd3; sel = 2'd1; wdata = 8'h21; wr_req = 1;
    @(negedge clk); sel = 2'd2; wdata = 8'h42;
    @(negedge clk); wr_req = 0;
    @(negedge clk); cs_n = 1;
    repeat (S + 2) @(negedge clk);
    rd_chk("R10 later wins", 14, 8'h42);
    rd_chk("R10 earlier dropped", 13, 8'h00);

    // R10 write beats transfer in same cycle
    @(negedge clk); cs_n = 0; bank = 2'd1; sel = 2'd1; wdata = 8'h55; wiper = 8'h66;
    wr_req = 1; xfer_req = 1;
    @(negedge clk); wr_req = 0; xfer_req = 0;
    @(negedge clk); cs_n = 1;
    repeat (S + 2) @(negedge clk);
    rd_chk("R10 write wins", 5, 8'h55);
    rd_chk("R10 transfer dropped", 1, 8'h77);
    check("R9 dr0 final", dr0, 8'hA5);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule